// File: doc/BRIEF.md
# Two-Stage Watchdog Frequency-Switch Controller

This block sits inside a programmable clock generator and lets software schedule a change of PLL settings. Two timer stages, a short soft stage and a longer hard stage, run once the global watchdog enable is switched on. When a stage that is enabled reaches zero, the block raises a sticky status flag and drives a one-cycle load strobe. The strobe carries that stage's preset CPU PLL divider, its SRC PLL divider and a 4-bit control word (the CPU mode for the soft stage, the CPU band for the hard stage) to the PLL control logic.

Each stage may also request an active-low system reset pulse. The hard stage may additionally recapture the three external frequency-select pins into a holding latch. Software programs the presets, the timers and the enables through a simple write port and arms the block last. The timers count pulses of an external time-base tick and not clock cycles. The write port and all control and status pins are plain level or strobe signals with no back-pressure: a write is taken in the cycle in which `wr_en` is high, and the load strobe must be consumed in the cycle it is shown.

Top module: `wdt_freq_switch`

## Requirements
- R1: After a synchronous reset (`srst` high at a clock edge), `pll_load`, `fs_stb`, `soft_status` and `hard_status` are 0 and `sys_reset_n` is 1.
- R2: Register addresses are: 0 = control, 1 = hard timer (8 bits), 2 = soft timer (4 bits), 3 = soft CPU divider, 4 = soft SRC divider, 5 = hard CPU divider, 6 = hard SRC divider, 7 = soft mode in bits [3:0] and hard band in bits [7:4]. The control bits are: bit0 the watchdog enable, bit1 the soft enable, bit2 the hard enable, bit3 the soft reset enable, bit4 the hard reset enable, bit5 the relatch enable. While bit0 is 0, no alarm fires and no status bit is set.
- R3: A control write that raises bit0 (edge N) loads both timers. Each tick high at a later edge lowers a nonzero count by one, and a count holds at zero. With soft timer value S and the soft stage enabled, `pll_load` is high in the cycle after the edge that follows the S-th counted tick (for S = 0, after edge N+1). In that cycle the bus shows the soft dividers, `pll_ctl` shows the soft mode, `pll_from_hard` is 0 and `soft_status` becomes 1.
- R4: The hard stage has the same timing, with the 8-bit hard timer. Its load shows the hard dividers, `pll_ctl` shows the hard band, `pll_from_hard` is 1 and `hard_status` becomes 1.
- R5: Status bits stay set while bit0 remains 1. A control write with bit0 = 0 clears both status bits.
- R6: `pll_load` is one cycle wide. Each stage fires at most once per rising edge of bit0, however many more ticks arrive.
- R7: When an enabled stage fires and its reset enable is set, `sys_reset_n` goes low in the same cycle as `pll_load` and stays low for exactly 4 cycles.
- R8: When the hard stage fires with relatch enabled, `fs_latched` takes `fs_in`, and `fs_stb` is high for that one cycle. Without a hard firing, or with relatch disabled, `fs_latched` keeps its value.
- R9: If both stages fire in the same cycle, a single load is shown, carrying the hard settings (`pll_from_hard` = 1), and both status bits are set.
- R10: A timer register write while bit0 is 1 does not change the running count. The alarm fires at the time given by the value loaded at the enable.
- R11: A stage whose own enable is 0 produces no load and no status. Its reset enable then has no effect, so `sys_reset_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base pulse that decrements the timers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fs_in | input | 3 | Frequency-select pins |
| pll_load | output | 1 | One-cycle PLL load strobe |
| pll_from_hard | output | 1 | Load carries hard-stage settings |
| pll_cpu_n | output | 8 | CPU PLL divider for the load |
| pll_src_n | output | 8 | SRC PLL divider for the load |
| pll_ctl | output | 4 | CPU mode (soft) or band (hard) |
| soft_status | output | 1 | Sticky soft-alarm flag |
| hard_status | output | 1 | Sticky hard-alarm flag |
| sys_reset_n | output | 1 | Active-low system reset pulse |
| fs_latched | output | 3 | Recaptured frequency-select value |
| fs_stb | output | 1 | One-cycle relatch strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit hard timer, a 4-bit soft timer and a 4-cycle reset pulse. These widths are small enough to sweep every soft preset, at half tick rate, and every one of the 256 hard presets, at full rate. The expected load cycle and the preset values for each run are computed from the timer value. This covers the zero preset, the all-ones counts and the tick gating completely. Directed runs add same-cycle firing, reset pulse width, relatch, ignored mid-run timer writes and enable gating.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_HTMR   = 3'd1;
  localparam logic [AW-1:0] A_STMR   = 3'd2;
  localparam logic [AW-1:0] A_S_CPU  = 3'd3;
  localparam logic [AW-1:0] A_S_SRC  = 3'd4;
  localparam logic [AW-1:0] A_H_CPU  = 3'd5;
  localparam logic [AW-1:0] A_H_SRC  = 3'd6;
  localparam logic [AW-1:0] A_MDBD   = 3'd7;

  typedef struct packed {
    logic relatch_en;
    logic hard_rst_en;
    logic soft_rst_en;
    logic hard_en;
    logic soft_en;
    logic on;
  } ctrl_t;
endpackage

// File: rtl/wdt_alarm_timer.sv
module wdt_alarm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  input  logic [W-1:0] preset,
  output logic         expired
);
  logic [W-1:0] cnt;
  logic         armed;

  assign expired = armed && (cnt == '0);

  always_ff @(posedge clk) begin
    if (srst || stop) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      armed <= 1'b1;
      cnt   <= preset;
    end else begin
      if (expired) armed <= 1'b0;
      if (tick && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  // R6: a stage expires for a single cycle per arming
  p_fire_once_r6: assert property (@(posedge clk) disable iff (srst)
    expired |=> !expired);

  // R3: a count at zero holds until the next start
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (srst)
    (cnt == '0 && !start) |=> cnt == '0);

  // R10: without a start the count never rises
  p_no_reload_r10: assert property (@(posedge clk) disable iff (srst)
    !start |=> cnt <= $past(cnt));
endmodule

// File: rtl/wdt_reset_pulser.sv
module wdt_reset_pulser #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic srst,
  input  logic trig,
  output logic pulse_n
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (srst)                cnt <= '0;
    else if (trig)           cnt <= CW'(CYC);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign pulse_n = (cnt == '0);

  // R7: a reset pulse never lasts a single cycle
  p_reset_width_r7: assert property (@(posedge clk) disable iff (srst)
    $fell(pulse_n) |=> !pulse_n);
endmodule

// File: rtl/wdt_freq_switch.sv
module wdt_freq_switch
  import wdt_pkg::*;
#(
  parameter int HARD_W  = 8,
  parameter int SOFT_W  = 4,
  parameter int NDIV_W  = 8,
  parameter int CTL_W   = 4,
  parameter int FS_W    = 3,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [FS_W-1:0]   fs_in,
  output logic              pll_load,
  output logic              pll_from_hard,
  output logic [NDIV_W-1:0] pll_cpu_n,
  output logic [NDIV_W-1:0] pll_src_n,
  output logic [CTL_W-1:0]  pll_ctl,
  output logic              soft_status,
  output logic              hard_status,
  output logic              sys_reset_n,
  output logic [FS_W-1:0]   fs_latched,
  output logic              fs_stb
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [HARD_W-1:0] htmr_q;
  logic [SOFT_W-1:0] stmr_q;
  logic [NDIV_W-1:0] s_cpu_q, s_src_q, h_cpu_q, h_src_q;
  logic [CTL_W-1:0]  mode_q, band_q;

  logic wr_ctrl, start, stop;
  logic s_exp, h_exp, s_hit, h_hit, rst_trig;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign start   = wr_ctrl && wr_data[0] && !ctrl_q.on;
  assign stop    = wr_ctrl && !wr_data[0];

  always_ff @(posedge clk) begin
    if (srst) begin
      ctrl_q  <= '0;
      htmr_q  <= '0;
      stmr_q  <= '0;
      s_cpu_q <= '0;
      s_src_q <= '0;
      h_cpu_q <= '0;
      h_src_q <= '0;
      mode_q  <= '0;
      band_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_HTMR:  htmr_q  <= wr_data[HARD_W-1:0];
        A_STMR:  stmr_q  <= wr_data[SOFT_W-1:0];
        A_S_CPU: s_cpu_q <= wr_data[NDIV_W-1:0];
        A_S_SRC: s_src_q <= wr_data[NDIV_W-1:0];
        A_H_CPU: h_cpu_q <= wr_data[NDIV_W-1:0];
        A_H_SRC: h_src_q <= wr_data[NDIV_W-1:0];
        A_MDBD: begin
          mode_q <= wr_data[CTL_W-1:0];
          band_q <= wr_data[2*CTL_W-1:CTL_W];
        end
        default: ;
      endcase
    end
  end

  wdt_alarm_timer #(.W(SOFT_W)) u_soft (
    .clk(clk), .srst(srst), .start(start), .stop(stop), .tick(tick),
    .preset(stmr_q), .expired(s_exp)
  );

  wdt_alarm_timer #(.W(HARD_W)) u_hard (
    .clk(clk), .srst(srst), .start(start), .stop(stop), .tick(tick),
    .preset(htmr_q), .expired(h_exp)
  );

  assign s_hit    = s_exp && ctrl_q.soft_en && !stop;
  assign h_hit    = h_exp && ctrl_q.hard_en && !stop;
  assign rst_trig = (s_hit && ctrl_q.soft_rst_en) || (h_hit && ctrl_q.hard_rst_en);

  always_ff @(posedge clk) begin
    if (srst) begin
      pll_load      <= 1'b0;
      pll_from_hard <= 1'b0;
      pll_cpu_n     <= '0;
      pll_src_n     <= '0;
      pll_ctl       <= '0;
      soft_status   <= 1'b0;
      hard_status   <= 1'b0;
      fs_latched    <= '0;
      fs_stb        <= 1'b0;
    end else begin
      pll_load <= s_hit || h_hit;
      fs_stb   <= h_hit && ctrl_q.relatch_en;
      if (h_hit) begin
        pll_from_hard <= 1'b1;
        pll_cpu_n     <= h_cpu_q;
        pll_src_n     <= h_src_q;
        pll_ctl       <= band_q;
      end else if (s_hit) begin
        pll_from_hard <= 1'b0;
        pll_cpu_n     <= s_cpu_q;
        pll_src_n     <= s_src_q;
        pll_ctl       <= mode_q;
      end
      if (h_hit && ctrl_q.relatch_en) fs_latched <= fs_in;
      if (stop || !ctrl_q.on) begin
        soft_status <= 1'b0;
        hard_status <= 1'b0;
      end else begin
        if (s_hit) soft_status <= 1'b1;
        if (h_hit) hard_status <= 1'b1;
      end
    end
  end

  wdt_reset_pulser #(.CYC(RST_CYC)) u_rst (
    .clk(clk), .srst(srst), .trig(rst_trig), .pulse_n(sys_reset_n)
  );

  // R2: a load only appears while the watchdog is enabled
  p_load_needs_wde_r2: assert property (@(posedge clk) disable iff (srst)
    pll_load |-> ctrl_q.on);

  // R5: status flags never outlive the watchdog enable
  p_status_needs_wde_r5: assert property (@(posedge clk) disable iff (srst)
    (soft_status || hard_status) |-> ctrl_q.on);

  // R5: status flags are sticky while enabled
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (srst)
    (hard_status && ctrl_q.on && !stop) |=> hard_status);

  // R3: a soft-sourced load comes with the soft flag set
  p_soft_load_flag_r3: assert property (@(posedge clk) disable iff (srst)
    (pll_load && !pll_from_hard) |-> soft_status);

  // R8: a relatch strobe only accompanies a hard firing
  p_latch_with_hard_r8: assert property (@(posedge clk) disable iff (srst)
    fs_stb |-> (hard_status && pll_load && pll_from_hard));
endmodule

// File: tb/wdt_freq_switch_test.sv
module wdt_freq_switch_test;
  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fs_in = '0;
  logic       pll_load, pll_from_hard, soft_status, hard_status, sys_reset_n, fs_stb;
  logic [7:0] pll_cpu_n, pll_src_n;
  logic [3:0] pll_ctl;
  logic [2:0] fs_latched;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int first_load, loads, cap_cpu, cap_src, cap_ctl, cap_hard;
  int first_rst, rlow, first_fs, fs_cnt;

  always #5 clk = ~clk;

  wdt_freq_switch uut (
    .clk(clk), .srst(srst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fs_in(fs_in), .pll_load(pll_load),
    .pll_from_hard(pll_from_hard), .pll_cpu_n(pll_cpu_n), .pll_src_n(pll_src_n),
    .pll_ctl(pll_ctl), .soft_status(soft_status), .hard_status(hard_status),
    .sys_reset_n(sys_reset_n), .fs_latched(fs_latched), .fs_stb(fs_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int st, input int ht, input int sc, input int ss,
                       input int hc, input int hs, input int mb);
    wr(0, 0);
    wr(1, ht); wr(2, st); wr(3, sc); wr(4, ss);
    wr(5, hc); wr(6, hs); wr(7, mb);
  endtask

  // Runs ncyc cycles from just after the enabling edge N; cycle c follows edge N+c.
  task automatic watch(input int ncyc, input bit half, input int mid_c, input int mid_v);
    first_load = -1; loads = 0; first_rst = -1; rlow = 0; first_fs = -1; fs_cnt = 0;
    cap_cpu = -1; cap_src = -1; cap_ctl = -1; cap_hard = -1;
    for (int c = 0; c < ncyc; c++) begin
      tick = half ? ((c + 1) % 2 == 0) : 1'b1;
      wr_en = (c + 1 == mid_c);
      wr_addr = 3'd1; wr_data = 8'(mid_v);
      @(negedge clk);
      if (pll_load) begin
        loads++;
        if (first_load < 0) begin
          first_load = c + 1;
          cap_cpu = pll_cpu_n; cap_src = pll_src_n; cap_ctl = pll_ctl;
          cap_hard = pll_from_hard;
        end
      end
      if (!sys_reset_n) begin
        rlow++;
        if (first_rst < 0) first_rst = c + 1;
      end
      if (fs_stb) begin
        fs_cnt++;
        if (first_fs < 0) first_fs = c + 1;
      end
    end
    tick = 1'b0; wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    srst = 1'b0;
    // R1 reset state
    chk("R1 pll_load", pll_load, 0);
    chk("R1 fs_stb", fs_stb, 0);
    chk("R1 soft_status", soft_status, 0);
    chk("R1 hard_status", hard_status, 0);
    chk("R1 sys_reset_n", sys_reset_n, 1);

    // R2: every enable but the watchdog bit
    setup(1, 1, 1, 1, 1, 1, 0);
    wr(0, 8'h3E);
    watch(40, 0, -1, 0);
    chk("R2 loads", loads, 0);
    chk("R2 soft_status", soft_status, 0);
    chk("R2 hard_status", hard_status, 0);
    chk("R2 reset low cycles", rlow, 0);

    // R3 soft sweep at half tick rate
    for (int t = 0; t < 16; t++) begin
      setup(t, 0, t + 16, (3 * t + 1) & 255, 0, 0, ((~t & 15) << 4) | t);
      wr(0, 8'h03);
      watch(2 * t + 8, 1, -1, 0);
      chk("R3 soft load cycle", first_load, 2 * t + 1);
      chk("R6 soft load count", loads, 1);
      chk("R3 soft cpu_n", cap_cpu, t + 16);
      chk("R3 soft src_n", cap_src, (3 * t + 1) & 255);
      chk("R3 soft mode", cap_ctl, t);
      chk("R3 soft from_hard", cap_hard, 0);
      chk("R3 soft_status", soft_status, 1);
      chk("R3 hard_status", hard_status, 0);
    end

    // R4 hard sweep at full tick rate
    for (int t = 0; t < 256; t++) begin
      setup(0, t, 0, 0, 255 - t, t ^ 8'h5A, (t & 15) << 4);
      wr(0, 8'h05);
      watch(t + 5, 0, -1, 0);
      chk("R4 hard load cycle", first_load, t + 1);
      chk("R6 hard load count", loads, 1);
      chk("R4 hard cpu_n", cap_cpu, 255 - t);
      chk("R4 hard src_n", cap_src, t ^ 8'h5A);
      chk("R4 hard band", cap_ctl, t & 15);
      chk("R4 hard from_hard", cap_hard, 1);
      chk("R4 hard_status", hard_status, 1);
      chk("R4 soft_status", soft_status, 0);
    end

    // R5 and R6: both stages at different times, sticky status, clear
    setup(2, 9, 10, 11, 12, 13, 8'h21);
    wr(0, 8'h07);
    watch(30, 0, -1, 0);
    chk("R6 two loads", loads, 2);
    chk("R3 first load", first_load, 3);
    chk("R5 soft held", soft_status, 1);
    chk("R5 hard held", hard_status, 1);
    wr(0, 8'h00);
    chk("R5 soft cleared", soft_status, 0);
    chk("R5 hard cleared", hard_status, 0);

    // R7 soft reset pulse
    setup(2, 0, 1, 1, 1, 1, 0);
    wr(0, 8'h0B);
    watch(15, 0, -1, 0);
    chk("R7 soft rst start", first_rst, 3);
    chk("R7 soft rst width", rlow, 4);
    // R7 hard reset pulse
    setup(0, 4, 1, 1, 1, 1, 0);
    wr(0, 8'h15);
    watch(15, 0, -1, 0);
    chk("R7 hard rst start", first_rst, 5);
    chk("R7 hard rst width", rlow, 4);

    // R11 soft reset enable without soft enable
    setup(1, 5, 1, 1, 7, 7, 0);
    wr(0, 8'h0D);
    watch(15, 0, -1, 0);
    chk("R11 loads", loads, 1);
    chk("R11 load cycle", first_load, 6);
    chk("R11 reset stays high", rlow, 0);
    chk("R11 soft_status", soft_status, 0);

    // R8 relatch
    fs_in = 3'd5;
    setup(0, 3, 0, 0, 1, 1, 0);
    wr(0, 8'h25);
    watch(10, 0, -1, 0);
    chk("R8 strobe cycle", first_fs, 4);
    chk("R8 strobe count", fs_cnt, 1);
    chk("R8 latched", fs_latched, 5);
    fs_in = 3'd2;
    watch(10, 0, -1, 0);
    chk("R8 no extra strobe", fs_cnt, 0);
    chk("R8 latch held", fs_latched, 5);
    fs_in = 3'd6;
    setup(0, 3, 0, 0, 1, 1, 0);
    wr(0, 8'h05);
    watch(10, 0, -1, 0);
    chk("R8 relatch off strobe", fs_cnt, 0);
    chk("R8 relatch off held", fs_latched, 5);

    // R9 simultaneous firing
    setup(3, 3, 40, 41, 50, 51, 8'h9C);
    wr(0, 8'h07);
    watch(12, 0, -1, 0);
    chk("R9 single load", loads, 1);
    chk("R9 load cycle", first_load, 4);
    chk("R9 from_hard", cap_hard, 1);
    chk("R9 cpu_n", cap_cpu, 50);
    chk("R9 src_n", cap_src, 51);
    chk("R9 band", cap_ctl, 9);
    chk("R9 soft_status", soft_status, 1);
    chk("R9 hard_status", hard_status, 1);

    // R10 timer write while running
    setup(0, 10, 0, 0, 1, 1, 0);
    wr(0, 8'h05);
    watch(20, 0, 3, 1);
    chk("R10 load cycle", first_load, 11);
    chk("R10 load count", loads, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule